// File: doc/BRIEF.md
# Condition code and branch resolver

This block holds the three-flag condition code of a 16-bit processor and decides conditional branches. Every cycle it looks at the register-write strobe together with the opcode of the instruction producing that result. When the opcode is one that sets flags, the written value is classed as negative, zero or strictly positive. The class is latched into a one-hot flag register on the clock edge.

Separately, it decodes the instruction word being resolved. If that word is a branch, it tests the instruction's three-bit mask against the held flags and raises a taken signal. It also computes the PC-relative target from the incremented program counter and a 9-bit signed offset.

All pins are plain control and status signals. There is no streamed data path, so there is no valid/ready handshake and no back-pressure. The write strobe is sampled on every rising edge. The branch outputs are combinational, follow their inputs within the same cycle and cannot be stalled.

Top module: `cc_branch_unit`

## Requirements
- R1: After reset, `cc_flags` (bit order {N,Z,P}) always has exactly one bit set.
- R2: On a rising edge where `wr_en` is 1 and `wr_opcode` is one of 0001, 0101, 1001, 0010, 0110, 1010 or 1110, `cc_flags` takes the class of `wr_data` from the next cycle on.
- R3: The class treats `wr_data` as 16-bit two's complement. It is 100 (N) when bit 15 is 1, 010 (Z) when all bits are 0, and 001 (P) otherwise.
- R4: When `wr_en` is 0, or `wr_opcode` is any other value (0000, 0011, 0100, 0111, 1000, 1011, 1100, 1101, 1111), `cc_flags` keeps its value.
- R5: `br_taken` is 1 exactly when `instr[15:12]` is 0000 and (`instr[11:9]` AND `cc_flags`) is non-zero. `instr[11]` tests N, `instr[10]` tests Z and `instr[9]` tests P. A mask of 111 is always taken and a mask of 000 is never taken.
- R6: `br_taken` is 0 whenever `instr[15:12]` is not 0000, whatever `instr[11:9]` holds.
- R7: `br_target` equals `pc_next` plus `instr[8:0]` sign-extended to 16 bits, modulo 2^16, in the same cycle. For example, `pc_next` x3003 with offset x010 gives x3013.
- R8: An asynchronous active-low reset sets `cc_flags` to 010 (Z).
- R9: A result written in a cycle does not affect `br_taken` in that same cycle. The branch always tests the flags held before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register-write strobe |
| wr_opcode | input | 4 | Opcode of the instruction writing `wr_data` |
| wr_data | input | 16 | Value written to the destination register |
| instr | input | 16 | Instruction word being resolved |
| pc_next | input | 16 | Address of the instruction after `instr` |
| cc_flags | output | 3 | Held flags {N,Z,P} |
| br_taken | output | 1 | Branch decision |
| br_target | output | 16 | PC-relative branch target |

## Verification
Flag-setting writes use the most negative value, zero, one and the largest positive value. These tell apart a sign test from a magnitude test and a zero test. Every one of the sixteen write opcodes is sent with the strobe high, with data chosen to change the flags. This separates the seven updating opcodes from the nine that must leave the flags alone. The strobe is also held low under an updating opcode. Branches are tried with mask 111, mask 000, single-bit masks that match and that miss, and a non-branch word carrying mask bits. Positive and negative offsets check the target arithmetic, and a write in the same cycle as a branch checks that the decision uses the old flags.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int DATA_W  = 16;
  localparam int OP_W    = 4;
  localparam int NFLAGS  = 3;

  typedef logic [NFLAGS-1:0] nzp_t;  // {N,Z,P}
  typedef logic [OP_W-1:0]   op_t;

  localparam nzp_t NZP_NEG  = 3'b100;
  localparam nzp_t NZP_ZERO = 3'b010;
  localparam nzp_t NZP_POS  = 3'b001;

  localparam op_t OP_BRANCH = 4'b0000;
  localparam op_t OP_ADD    = 4'b0001;
  localparam op_t OP_LD     = 4'b0010;
  localparam op_t OP_AND    = 4'b0101;
  localparam op_t OP_LDR    = 4'b0110;
  localparam op_t OP_NOT    = 4'b1001;
  localparam op_t OP_LDI    = 4'b1010;
  localparam op_t OP_LEA    = 4'b1110;
endpackage

// File: rtl/cc_classify.sv
module cc_classify
  import cc_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0] value,
  output nzp_t         nzp
);
  always_comb begin
    if (value[W-1])      nzp = NZP_NEG;
    else if (value == '0) nzp = NZP_ZERO;
    else                 nzp = NZP_POS;
  end
endmodule

// File: rtl/cc_write_filter.sv
module cc_write_filter
  import cc_pkg::*;
(
  input  logic wr_en,
  input  op_t  wr_opcode,
  output logic upd
);
  logic sets_flags;

  always_comb begin
    unique case (wr_opcode)
      OP_ADD, OP_AND, OP_NOT,
      OP_LD, OP_LDR, OP_LDI, OP_LEA: sets_flags = 1'b1;
      default:                       sets_flags = 1'b0;
    endcase
  end

  assign upd = wr_en & sets_flags;
endmodule

// File: rtl/cc_flag_reg.sv
module cc_flag_reg
  import cc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic upd,
  input  nzp_t nzp_in,
  output nzp_t flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flags <= NZP_ZERO;
    else if (upd) flags <= nzp_in;
  end
endmodule

// File: rtl/cc_branch_eval.sv
module cc_branch_eval
  import cc_pkg::*;
#(
  parameter int W        = DATA_W,
  parameter int OFF_W    = 9,
  parameter int MASK_LSB = 9
) (
  input  logic [W-1:0] instr,
  input  logic [W-1:0] pc_next,
  input  nzp_t         flags,
  output logic         taken,
  output logic [W-1:0] target
);
  localparam int OPC_LSB = W - OP_W;
  localparam int EXT_W   = W - OFF_W;

  logic [NFLAGS-1:0] mask;
  logic [NFLAGS-1:0] hit;
  logic              is_branch;
  logic [W-1:0]      offset;

  assign mask      = instr[MASK_LSB +: NFLAGS];
  assign is_branch = (instr[OPC_LSB +: OP_W] == OP_BRANCH);

  for (genvar i = 0; i < NFLAGS; i++) begin : g_hit
    assign hit[i] = mask[i] & flags[i];
  end

  assign taken  = is_branch & (|hit);
  assign offset = {{EXT_W{instr[OFF_W-1]}}, instr[OFF_W-1:0]};
  assign target = pc_next + offset;
endmodule

// File: rtl/cc_branch_unit.sv
module cc_branch_unit
  import cc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OP_W-1:0]   wr_opcode,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] instr,
  input  logic [DATA_W-1:0] pc_next,
  output logic [NFLAGS-1:0] cc_flags,
  output logic              br_taken,
  output logic [DATA_W-1:0] br_target
);
  logic upd;
  nzp_t nzp_new;
  nzp_t flags_q;

  cc_write_filter u_filter (
    .wr_en     (wr_en),
    .wr_opcode (wr_opcode),
    .upd       (upd)
  );

  cc_classify #(.W(DATA_W)) u_class (
    .value (wr_data),
    .nzp   (nzp_new)
  );

  cc_flag_reg u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd    (upd),
    .nzp_in (nzp_new),
    .flags  (flags_q)
  );

  cc_branch_eval #(.W(DATA_W), .OFF_W(9), .MASK_LSB(9)) u_branch (
    .instr   (instr),
    .pc_next (pc_next),
    .flags   (flags_q),
    .taken   (br_taken),
    .target  (br_target)
  );

  assign cc_flags = flags_q;
endmodule

// File: rtl/cc_branch_unit_chk.sv
module cc_branch_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [3:0]  wr_opcode,
  input logic [15:0] wr_data,
  input logic [15:0] instr,
  input logic [2:0]  cc_flags,
  input logic        br_taken
);
  function automatic logic op_sets(input logic [3:0] op);
    return (op == 4'b0001) || (op == 4'b0101) || (op == 4'b1001) ||
           (op == 4'b0010) || (op == 4'b0110) || (op == 4'b1010) ||
           (op == 4'b1110);
  endfunction

  // R1
  flags_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cc_flags) == 1);

  // R4
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && op_sets(wr_opcode)) |=> cc_flags == $past(cc_flags));

  // R3
  flags_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op_sets(wr_opcode) && wr_data[15]) |=> cc_flags == 3'b100);

  // R3
  flags_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op_sets(wr_opcode) && wr_data == 16'h0) |=> cc_flags == 3'b010);

  // R2
  flags_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op_sets(wr_opcode) && !wr_data[15] && wr_data != 16'h0)
    |=> cc_flags == 3'b001);

  // R6
  nonbranch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[15:12] != 4'b0000) |-> !br_taken);

  // R5
  mask_all_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[15:12] == 4'b0000 && instr[11:9] == 3'b111) |-> br_taken);

  // R5
  mask_none_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[11:9] == 3'b000) |-> !br_taken);
endmodule

bind cc_branch_unit cc_branch_unit_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_opcode (wr_opcode),
  .wr_data   (wr_data),
  .instr     (instr),
  .cc_flags  (cc_flags),
  .br_taken  (br_taken)
);

// File: tb/tb_cc_branch_unit.sv
module tb_cc_branch_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_opcode = 4'h0;
  logic [15:0] wr_data = 16'h0;
  logic [15:0] instr = 16'hF000;
  logic [15:0] pc_next = 16'h0;
  logic [2:0]  cc_flags;
  logic        br_taken;
  logic [15:0] br_target;

  always #10 clk = ~clk;  // 50 MHz

  cc_branch_unit dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_opcode(wr_opcode),
    .wr_data(wr_data), .instr(instr), .pc_next(pc_next),
    .cc_flags(cc_flags), .br_taken(br_taken), .br_target(br_target)
  );

  typedef struct {
    logic [2:0]  flags;
    logic        taken;
    logic [15:0] target;
    string       ftag;
    string       btag;
  } exp_t;

  exp_t        sb[$];
  int          total = 0;
  int          bad = 0;
  logic [2:0]  mflags = 3'b010;
  bit          finished = 1'b0;

  function automatic logic sets(input logic [3:0] op);
    return op inside {4'b0001, 4'b0101, 4'b1001, 4'b0010,
                      4'b0110, 4'b1010, 4'b1110};
  endfunction

  function automatic logic [2:0] cls(input logic [15:0] v);
    if (v[15]) return 3'b100;
    if (v == 16'h0) return 3'b010;
    return 3'b001;
  endfunction

  task automatic step(input logic we, input logic [3:0] op, input logic [15:0] d,
                      input logic [15:0] ins, input logic [15:0] pc,
                      input string ftag, input string btag);
    exp_t e;
    @(negedge clk);
    wr_en = we; wr_opcode = op; wr_data = d; instr = ins; pc_next = pc;
    e.flags  = mflags;
    e.taken  = (ins[15:12] == 4'b0000) && ((ins[11:9] & mflags) != 3'b000);
    e.target = pc + {{7{ins[8]}}, ins[8:0]};
    e.ftag = ftag; e.btag = btag;
    sb.push_back(e);
    if (we && sets(op)) mflags = cls(d);
  endtask

  always begin
    @(negedge clk);
    #2;
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      total++;
      if (cc_flags !== e.flags) begin
        bad++;
        $display("FAIL %s flags act=%b exp=%b", e.ftag, cc_flags, e.flags);
      end
      total++;
      if (br_taken !== e.taken) begin
        bad++;
        $display("FAIL %s taken act=%b exp=%b", e.btag, br_taken, e.taken);
      end
      total++;
      if (br_target !== e.target) begin
        bad++;
        $display("FAIL R7 target act=%h exp=%h", br_target, e.target);
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // R8 reset value, R5 mask 010 taken on Z
    step(0, 4'h0, 16'h0, 16'h0410, 16'h3003, "R8", "R5");
    // R3 negative extreme via ADD; R7 example target x3013
    step(1, 4'b0001, 16'h8000, 16'h0E10, 16'h3003, "R1", "R5");
    // R6 non-branch word with full mask
    step(0, 4'h0, 16'h0, 16'h1E00, 16'h4000, "R3", "R6");
    // R5 mask 100 taken on N, R4 store with strobe high leaves flags
    step(1, 4'b0011, 16'h0001, 16'h0801, 16'h4000, "R3", "R5");
    // R9 same-cycle LEA write of zero; branch still sees N; mask 001 misses
    step(1, 4'b1110, 16'h0000, 16'h0200, 16'h5000, "R4", "R9");
    // R5 mask 101 misses on Z; R3 LDR of 0x7FFF; negative offset
    step(1, 4'b0110, 16'h7FFF, 16'h0BFF, 16'h5000, "R3", "R5");
    // R5 mask 000 never taken; R4 strobe low under ADD
    step(0, 4'b0001, 16'h8000, 16'h0100, 16'h0000, "R2", "R5");
    // R5 mask 001 taken on P; wrap-around target
    step(0, 4'h0, 16'h0, 16'h0300, 16'h0001, "R4", "R5");
    // R2 and R4: every write opcode, data chosen to flip the flags
    for (int k = 0; k < 16; k++) begin
      logic [15:0] d;
      d = (mflags == 3'b001) ? 16'h8000 : ((mflags == 3'b100) ? 16'h0000 : 16'h0001);
      step(1, k[3:0], d, 16'h0E05, 16'h1000 + 16'(k), sets(k[3:0]) ? "R2" : "R4", "R5");
    end
    step(0, 4'h0, 16'h0, 16'h0F00, 16'h2222, "R1", "R5");
    step(1, 4'b1001, 16'h0001, 16'hF1FF, 16'h2222, "R1", "R6");
    step(0, 4'h0, 16'h0, 16'h0200, 16'h2222, "R2", "R5");
    @(negedge clk);
    #4;
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule